// File: doc/BRIEF.md
# USB Root Port Speed-Detect Sequencer

This block runs the root port of an embedded USB host that has two controllers: a high-speed controller and a companion controller for full- and low-speed devices. It watches a line-level attach indication. When a device appears, it reports the new connection through sticky change flags and an interrupt. A low-speed device goes straight to the companion controller. Any other device first gets a timed bus reset. During that reset the block records whether the high-speed chirp handshake succeeded.

The reset and the settle time that follows it are counted in pulses of a 1 kHz enable input, and parameters set both counts. At the end of the settle interval the enable bit decides the speed. If enable is set, the high-speed controller keeps the port. If it is clear, the owner bit hands the port to the companion controller. The high-speed side then stops seeing the device, records a disconnect and raises its change flags again. Software clears each change flag by writing a one to it.

A detach at any point returns the port to idle. It also cancels any reset in progress and flags the change.

Top module: `usb_root_port_seq`

## Requirements
- R1: When the port is idle and `line_attach` is high at a clock edge, `st_connect`, `st_connect_chg` and `st_port_chg` are all 1 after that edge.
- R2: If `line_low_speed` is also high at that edge, `st_reset` never asserts. One edge later `st_owner` and `route_companion` become 1 and `st_connect` returns to 0.
- R3: If `line_low_speed` is low at that edge, `st_reset` asserts together with `st_connect`. It is cleared on the edge where the RESET_TICKS-th `tick_1k` pulse after entry is sampled.
- R4: When the reset ends, `st_enable` becomes 1 only if `chirp_ok` was high in at least one cycle while the reset was active, including the cycle in which it ends. `st_enable` is never 1 while `st_reset` is 1.
- R5: After the reset, the port waits SETTLE_TICKS `tick_1k` pulses. If `st_enable` is 1, the high-speed controller keeps the port: `st_owner` stays 0 and `st_connect` stays 1.
- R6: If `st_enable` is 0 after the settle interval, `st_owner` becomes 1 on the next edge and `st_connect` drops to 0. On that same edge `st_connect_chg` and `st_port_chg` are set again.
- R7: A cycle with `clr_wr`=1 clears `st_connect_chg` when `clr_data[0]`=1 and clears `st_port_chg` when `clr_data[1]`=1, effective after that edge. A set event in the same cycle wins over the clear.
- R8: A `clr_wr` cycle leaves any change flag whose `clr_data` bit is 0 unchanged.
- R9: `irq` is 1 exactly while at least one of `st_connect_chg` and `st_port_chg` is 1.
- R10: If `line_attach` is low at an edge while the port is not idle, then after that edge `st_reset`, `st_enable`, `st_owner` and `st_connect` are 0 and both change flags are 1. The next attach starts a fresh sequence.
- R11: While `rst_n` is low at a clock edge, every output is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1k | input | 1 | One-cycle pulse per millisecond |
| line_attach | input | 1 | A device is present on the line (synchronous) |
| line_low_speed | input | 1 | Line idle state indicates a low-speed device |
| chirp_ok | input | 1 | High-speed chirp handshake succeeded |
| clr_wr | input | 1 | Write strobe for the change flags |
| clr_data | input | 2 | Write-one-to-clear data: bit 0 connect change, bit 1 port change |
| st_connect | output | 1 | Connect status as seen by the high-speed controller |
| st_connect_chg | output | 1 | Sticky connect-change flag |
| st_enable | output | 1 | Port enabled (high-speed device) |
| st_reset | output | 1 | Bus reset in progress |
| st_owner | output | 1 | Port owned by the companion controller |
| st_port_chg | output | 1 | Sticky port-change-detected flag |
| irq | output | 1 | Interrupt request |
| route_companion | output | 1 | Routes the port to the companion controller |

## Verification
The assertions assume that `line_attach` and `line_low_speed` are already synchronous to `clk`. They also assume that `tick_1k` is a single-cycle pulse and that a clear write is a one-cycle strobe. The stimulus changes inputs only on the falling edge and produces `tick_1k` from a free-running divider, one pulse every fourth cycle. It holds `line_low_speed` steady around each attach and pulses `chirp_ok` only during a reset. Detaches are placed inside the reset and settle intervals as well as in the owned states.

// File: rtl/usbport_pkg.sv
// Shared types for the root-port speed-detect sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package usbport_pkg;

    // Port sequencing phases
    typedef enum logic [2:0] {
        PS_IDLE,
        PS_BUSRST,
        PS_SETTLE,
        PS_HS,
        PS_HANDOFF,
        PS_COMP
    } port_state_e;

    // Bit positions of the sticky change flags; the clear data uses these positions
    localparam int CHG_BITS = 2;
    localparam int CHG_CONN = 0;
    localparam int CHG_PORT = 1;

endpackage

// File: rtl/usbport_tick_timer.sv
// Millisecond interval counter.
// Counts tick pulses while run is high and pulses done on the tick that
// completes (last+1) ticks. Dropping run clears the count.
// Assumes: tick is a single-cycle enable; last is stable while run is high,
// except on the done edge.
module usbport_tick_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] last,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    assign done = run && tick && (cnt_q == last);

    // Count ticks within the current interval
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (done) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last)); // R3

endmodule

// File: rtl/usbport_w1c_bits.sv
// Sticky flag bank with write-one-to-clear.
// A set request wins over a clear in the same cycle; a zero data bit leaves
// its flag untouched.
// Assumes: clr_wr is a single-cycle write strobe.
module usbport_w1c_bits #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] q
);

    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        logic flag_q;

        // Hold one sticky flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set[gi]) begin
                flag_q <= 1'b1;
            end else if (clr_wr && clr_data[gi]) begin
                flag_q <= 1'b0;
            end
        end

        assign q[gi] = flag_q;

        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_data[gi] && !set[gi]) |=> !flag_q); // R7
        AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && !(clr_wr && clr_data[gi])) |=> flag_q); // R8
    end

endmodule

// File: rtl/usb_root_port_seq.sv
// Root-port speed-detect sequencer for a host with a high-speed controller
// and a full/low-speed companion.
// Detects attach, runs a timed bus reset, samples the enable result after a
// settle time and hands full- and low-speed devices to the companion.
// Assumes: line inputs are synchronous to clk; tick_1k is a 1-cycle pulse.
module usb_root_port_seq
    import usbport_pkg::*;
#(
    parameter int RESET_TICKS  = 20,
    parameter int SETTLE_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1k,
    input  logic       line_attach,
    input  logic       line_low_speed,
    input  logic       chirp_ok,
    input  logic       clr_wr,
    input  logic [1:0] clr_data,
    output logic       st_connect,
    output logic       st_connect_chg,
    output logic       st_enable,
    output logic       st_reset,
    output logic       st_owner,
    output logic       st_port_chg,
    output logic       irq,
    output logic       route_companion
);

    localparam int MAX_TICKS = (RESET_TICKS > SETTLE_TICKS) ? RESET_TICKS : SETTLE_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RESET_TICKS - 1);
    localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_TICKS - 1);

    port_state_e         state_q, state_d;
    logic                connect_q, connect_d;
    logic                enable_q, enable_d;
    logic                busrst_q, busrst_d;
    logic                owner_q, owner_d;
    logic                chirp_q, chirp_d;
    logic [CHG_BITS-1:0] chg_set, chg_q;
    logic                tmr_run, tmr_done;
    logic [CNT_W-1:0]    tmr_last;

    assign tmr_run  = (state_q == PS_BUSRST) || (state_q == PS_SETTLE);
    assign tmr_last = (state_q == PS_SETTLE) ? SET_LAST : RST_LAST;

    usbport_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .tick  (tick_1k),
        .last  (tmr_last),
        .done  (tmr_done)
    );

    usbport_w1c_bits #(.N(CHG_BITS)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (chg_set),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .q        (chg_q)
    );

    // Next-state and port-status decisions
    always_comb begin
        state_d   = state_q;
        connect_d = connect_q;
        enable_d  = enable_q;
        busrst_d  = busrst_q;
        owner_d   = owner_q;
        chirp_d   = chirp_q;
        chg_set   = '0;
        if (state_q != PS_IDLE && !line_attach) begin
            state_d   = PS_IDLE;
            connect_d = 1'b0;
            enable_d  = 1'b0;
            busrst_d  = 1'b0;
            owner_d   = 1'b0;
            chirp_d   = 1'b0;
            chg_set   = '1;
        end else begin
            case (state_q)
                PS_IDLE: begin
                    if (line_attach) begin
                        connect_d = 1'b1;
                        chg_set   = '1;
                        if (line_low_speed) begin
                            state_d = PS_HANDOFF;
                        end else begin
                            state_d  = PS_BUSRST;
                            busrst_d = 1'b1;
                            chirp_d  = 1'b0;
                        end
                    end
                end
                PS_BUSRST: begin
                    if (chirp_ok) chirp_d = 1'b1;
                    if (tmr_done) begin
                        busrst_d = 1'b0;
                        enable_d = chirp_q | chirp_ok;
                        state_d  = PS_SETTLE;
                    end
                end
                PS_SETTLE: begin
                    if (tmr_done) state_d = enable_q ? PS_HS : PS_HANDOFF;
                end
                PS_HANDOFF: begin
                    owner_d   = 1'b1;
                    connect_d = 1'b0;
                    chg_set   = '1;
                    state_d   = PS_COMP;
                end
                default: ;
            endcase
        end
    end

    // Port state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PS_IDLE;
            connect_q <= 1'b0;
            enable_q  <= 1'b0;
            busrst_q  <= 1'b0;
            owner_q   <= 1'b0;
            chirp_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            connect_q <= connect_d;
            enable_q  <= enable_d;
            busrst_q  <= busrst_d;
            owner_q   <= owner_d;
            chirp_q   <= chirp_d;
        end
    end

    assign st_connect      = connect_q;
    assign st_enable       = enable_q;
    assign st_reset        = busrst_q;
    assign st_owner        = owner_q;
    assign route_companion = owner_q;
    assign st_connect_chg  = chg_q[CHG_CONN];
    assign st_port_chg     = chg_q[CHG_PORT];
    assign irq             = |chg_q;

    AST_ATTACH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_connect) |-> (st_connect_chg && st_port_chg)); // R1
    AST_LS_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && line_attach && line_low_speed) |=> !st_reset); // R2
    AST_RESET_NOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        st_reset |-> !st_enable); // R4
    AST_OWNER_HIDES_CONNECT: assert property (@(posedge clk) disable iff (!rst_n)
        st_owner |-> !st_connect); // R6
    AST_DETACH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_IDLE && !line_attach) |=>
        (!st_reset && !st_enable && !st_owner && !st_connect && st_connect_chg)); // R10

endmodule

// File: tb/usb_root_port_seq_test.sv
module usb_root_port_seq_test;

    localparam int RT = 20;
    localparam int ST = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1k = 1'b0;
    logic line_attach = 1'b0;
    logic line_low_speed = 1'b0;
    logic chirp_ok = 1'b0;
    logic clr_wr = 1'b0;
    logic [1:0] clr_data = 2'b00;
    logic st_connect, st_connect_chg, st_enable, st_reset;
    logic st_owner, st_port_chg, irq, route_companion;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    usb_root_port_seq #(.RESET_TICKS(RT), .SETTLE_TICKS(ST)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k),
        .line_attach(line_attach), .line_low_speed(line_low_speed),
        .chirp_ok(chirp_ok), .clr_wr(clr_wr), .clr_data(clr_data),
        .st_connect(st_connect), .st_connect_chg(st_connect_chg),
        .st_enable(st_enable), .st_reset(st_reset), .st_owner(st_owner),
        .st_port_chg(st_port_chg), .irq(irq), .route_companion(route_companion)
    );

    // Behavioural reference: phase 0 idle, 1 reset, 2 settle, 3 high speed, 4 handoff, 5 companion
    int ph = 0, m_ticks = 0;
    bit m_con, m_cc, m_pc, m_en, m_rst, m_own, m_chirp;

    always @(posedge clk) begin
        bit scc, spc;
        scc = 0; spc = 0;
        if (!rst_n) begin
            ph = 0; m_ticks = 0;
            m_con = 0; m_cc = 0; m_pc = 0; m_en = 0; m_rst = 0; m_own = 0; m_chirp = 0;
        end else begin
            if (ph != 0 && !line_attach) begin
                ph = 0; m_rst = 0; m_en = 0; m_own = 0; m_con = 0; scc = 1; spc = 1;
            end else if (ph == 0) begin
                if (line_attach) begin
                    m_con = 1; scc = 1; spc = 1;
                    if (line_low_speed) ph = 4;
                    else begin ph = 1; m_rst = 1; m_ticks = 0; m_chirp = 0; end
                end
            end else if (ph == 1) begin
                if (chirp_ok) m_chirp = 1;
                if (tick_1k) begin
                    m_ticks++;
                    if (m_ticks == RT) begin m_rst = 0; m_en = m_chirp; ph = 2; m_ticks = 0; end
                end
            end else if (ph == 2) begin
                if (tick_1k) begin
                    m_ticks++;
                    if (m_ticks == ST) begin ph = m_en ? 3 : 4; m_ticks = 0; end
                end
            end else if (ph == 4) begin
                m_own = 1; m_con = 0; scc = 1; spc = 1; ph = 5;
            end
            if (clr_wr && clr_data[0]) m_cc = 0;
            if (clr_wr && clr_data[1]) m_pc = 0;
            if (scc) m_cc = 1;
            if (spc) m_pc = 1;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the reference after every rising edge
    always begin
        @(posedge clk);
        #1;
        check("R1 st_connect", st_connect, m_con);
        check("R7 st_connect_chg", st_connect_chg, m_cc);
        check("R7 st_port_chg", st_port_chg, m_pc);
        check("R4 st_enable", st_enable, m_en);
        check("R3 st_reset", st_reset, m_rst);
        check("R6 st_owner", st_owner, m_own);
        check("R2 route_companion", route_companion, m_own);
        check("R9 irq", irq, m_cc | m_pc);
    end

    // Free-running millisecond pulse, every fourth cycle
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        tick_1k <= (cyc % 4 == 3);
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_clear(input logic [1:0] d);
        clr_wr = 1'b1; clr_data = d;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = 2'b00;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        cycles(4);
        // R11 reset state
        check("R11 reset connect", st_connect, 1'b0);
        check("R11 reset irq", irq, 1'b0);
        check("R11 reset owner", st_owner, 1'b0);
        rst_n = 1'b1;
        cycles(2);

        // Full-speed device: no chirp, handed to the companion
        line_attach = 1'b1;
        cycles(1);
        check("R1 attach connect", st_connect, 1'b1);
        check("R3 reset started", st_reset, 1'b1);
        write_clear(2'b11);
        cycles(110);
        check("R6 full speed owner", st_owner, 1'b1);
        check("R6 full speed connect dropped", st_connect, 1'b0);
        check("R6 change raised again", st_connect_chg, 1'b1);
        write_clear(2'b00);
        check("R8 zero write keeps connect change", st_connect_chg, 1'b1);
        check("R8 zero write keeps port change", st_port_chg, 1'b1);
        write_clear(2'b01);
        check("R7 connect change cleared", st_connect_chg, 1'b0);
        check("R8 port change kept", st_port_chg, 1'b1);
        write_clear(2'b10);
        check("R9 irq low after clears", irq, 1'b0);

        // Detach from companion ownership
        line_attach = 1'b0;
        cycles(1);
        check("R10 detach owner", st_owner, 1'b0);
        check("R10 detach change", st_connect_chg, 1'b1);
        write_clear(2'b11);
        cycles(3);

        // High-speed device: chirp seen during reset
        line_attach = 1'b1;
        cycles(30);
        chirp_ok = 1'b1;
        cycles(1);
        chirp_ok = 1'b0;
        cycles(80);
        check("R5 high speed enable", st_enable, 1'b1);
        check("R5 high speed owner", st_owner, 1'b0);
        check("R5 high speed connect", st_connect, 1'b1);
        write_clear(2'b11);
        cycles(5);
        line_attach = 1'b0;
        cycles(1);
        check("R10 detach enable", st_enable, 1'b0);
        write_clear(2'b11);
        cycles(3);

        // Low-speed device: straight to companion
        line_low_speed = 1'b1;
        line_attach = 1'b1;
        cycles(1);
        check("R2 low speed no reset", st_reset, 1'b0);
        cycles(1);
        check("R2 low speed routed", route_companion, 1'b1);
        cycles(5);
        line_attach = 1'b0;
        cycles(1);
        line_low_speed = 1'b0;
        write_clear(2'b11);
        cycles(3);

        // Detach in the middle of the bus reset
        line_attach = 1'b1;
        cycles(20);
        check("R3 reset held", st_reset, 1'b1);
        line_attach = 1'b0;
        cycles(1);
        check("R10 reset aborted", st_reset, 1'b0);
        cycles(3);

        // Detach during settle, then a clear and a set in the same cycle
        line_attach = 1'b1;
        cycles(84);
        line_attach = 1'b0;
        clr_wr = 1'b1; clr_data = 2'b11;
        cycles(1);
        clr_wr = 1'b0; clr_data = 2'b00;
        check("R7 set wins over clear", st_connect_chg, 1'b1);
        cycles(4);
        finish_run();
    end

endmodule